// File: doc/BRIEF.md
# Maskable Transfer-End Interrupt Source Bank

This block holds the interrupt state for transfer-completion events. Each source has a sticky raw flag, which a one-cycle event pulse sets, and an enable flag. Software changes the enable flag through two write-1 ports: one sets bits and the other clears bits. A third write-1 port clears raw flags. Each write port has a strobe and a data vector. When its strobe is high, only the bits written as 1 take effect.

The masked status is the raw flags ANDed with the enable flags. The interrupt line is a registered OR of the masked status. It behaves as a level: it stays high until software clears the raw flag or disables the source. Raw flags keep capturing events while a source is disabled. Enabling that source later therefore raises the line for any event that was held back. The bank is sized by a parameter for any number of sources. The default is one source.

Top module: `irq_src_bank`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `raw_o`, `en_o`, `masked_o` and `irq_o` are all zero.
- R2: An event pulse on bit i sets `raw_o[i]` at the next clock edge, whatever the value of `en_o[i]`.
- R3: A write on the enable-set port (`en_set_we`=1) sets each `en_o` bit whose data bit is 1. Bits written as 0 keep their value.
- R4: A write on the enable-clear port (`en_clr_we`=1) clears each `en_o` bit whose data bit is 1. Bits written as 0 keep their value.
- R5: When both enable ports write 1 to the same bit in one cycle, that bit ends up set.
- R6: A write on the source-clear port (`src_clr_we`=1) clears each `raw_o` bit whose data bit is 1. Other raw bits are unchanged.
- R7: If an event on bit i arrives in the same cycle as a source clear of bit i, `raw_o[i]` ends up 1.
- R8: `masked_o` equals `raw_o & en_o` in every cycle.
- R9: `irq_o` equals, one clock later, the OR of all `masked_o` bits. It stays high for as long as any masked bit stays set.
- R10: Data bits on a write port have no effect while that port's strobe is 0. Each source's flags change only through that source's own bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | Transfer-end event pulses, one per source |
| en_set_we | input | 1 | Strobe of the enable-set port |
| en_set_data | input | N_SRC | Bits to enable |
| en_clr_we | input | 1 | Strobe of the enable-clear port |
| en_clr_data | input | N_SRC | Bits to disable |
| src_clr_we | input | 1 | Strobe of the source-clear port |
| src_clr_data | input | N_SRC | Raw flags to clear |
| raw_o | output | N_SRC | Raw status flags |
| en_o | output | N_SRC | Enable readback |
| masked_o | output | N_SRC | Raw status ANDed with enable |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench first targets the two same-cycle collisions. If the source-clear collision were decided the wrong way, a completion would be lost. If the enable collision were decided the wrong way, the source would be left disabled. The bench then checks that an event arriving while the source is masked is kept, so that a later enable raises the line; a design that gated the raw flag with the enable would keep the line low. It also drives data with the strobes low, which must leave the flags as they are. Finally, an 11-bit pseudo-random sweep runs over every input field with two sources against an arithmetic model. This sweep catches any cross-talk between sources and any error in the one-cycle lag of the interrupt line.

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N_SRC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             en_set_we,
  input  logic [N_SRC-1:0] en_set_data,
  input  logic             en_clr_we,
  input  logic [N_SRC-1:0] en_clr_data,
  input  logic             src_clr_we,
  input  logic [N_SRC-1:0] src_clr_data,
  output logic [N_SRC-1:0] raw_o,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] masked_o,
  output logic             irq_o
);

  logic [N_SRC-1:0] raw_q, en_q;
  logic             irq_q;

  wire [N_SRC-1:0] set_mask = en_set_we  ? en_set_data  : '0;
  wire [N_SRC-1:0] clr_mask = en_clr_we  ? en_clr_data  : '0;
  wire [N_SRC-1:0] ack_mask = src_clr_we ? src_clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~ack_mask) | evt_i;
      en_q  <= (en_q & ~clr_mask) | set_mask;
      irq_q <= |(raw_q & en_q);
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign masked_o = raw_q & en_q;
  assign irq_o    = irq_q;

endmodule

module irq_src_bank_chk #(
  parameter int N_SRC = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt_i,
  input logic             en_set_we,
  input logic [N_SRC-1:0] en_set_data,
  input logic             en_clr_we,
  input logic [N_SRC-1:0] en_clr_data,
  input logic             src_clr_we,
  input logic [N_SRC-1:0] src_clr_data,
  input logic [N_SRC-1:0] raw_o,
  input logic [N_SRC-1:0] en_o,
  input logic [N_SRC-1:0] masked_o,
  input logic             irq_o
);

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((raw_o & $past(evt_i)) == $past(evt_i)));

  assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_we |=> ((en_o & $past(en_set_data)) == $past(en_set_data)));

  assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_we && !en_set_we) |=> ((en_o & $past(en_clr_data)) == '0));

  assert_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_set_we && !en_clr_we) |=> $stable(en_o));

  assert_src_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_clr_we |=> ((raw_o & $past(src_clr_data) & ~$past(evt_i)) == '0));

  assert_raw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_clr_we && evt_i == '0) |=> $stable(raw_o));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_o != '0) |=> irq_o);

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_o == '0) |=> !irq_o);

endmodule

bind irq_src_bank irq_src_bank_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/tb_irq_src_bank.sv
`timescale 1ns/1ps
module tb_irq_src_bank;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] evt_i = '0, en_set_data = '0, en_clr_data = '0, src_clr_data = '0;
  logic en_set_we = 1'b0, en_clr_we = 1'b0, src_clr_we = 1'b0;
  logic [N-1:0] raw_o, en_o, masked_o;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0] m_raw = '0, m_en = '0;
  logic m_irq = 1'b0;

  always #2.5 clk = ~clk;

  irq_src_bank #(.N_SRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .en_set_we(en_set_we), .en_set_data(en_set_data),
    .en_clr_we(en_clr_we), .en_clr_data(en_clr_data),
    .src_clr_we(src_clr_we), .src_clr_data(src_clr_data),
    .raw_o(raw_o), .en_o(en_o), .masked_o(masked_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " raw"}, 32'(raw_o), 32'(m_raw));
    check({req, " en"}, 32'(en_o), 32'(m_en));
    check({req, " R8 masked"}, 32'(masked_o), 32'(m_raw & m_en));
    check({req, " R9 irq"}, 32'(irq_o), 32'(m_irq));
  endtask

  task automatic step(input logic [N-1:0] ev, input logic sw, input logic [N-1:0] sd,
                      input logic cw, input logic [N-1:0] cd,
                      input logic qw, input logic [N-1:0] qd, input string req);
    logic [N-1:0] smask, cmask, qmask;
    @(negedge clk);
    evt_i = ev; en_set_we = sw; en_set_data = sd;
    en_clr_we = cw; en_clr_data = cd; src_clr_we = qw; src_clr_data = qd;
    @(posedge clk);
    smask = sw ? sd : '0;
    cmask = cw ? cd : '0;
    qmask = qw ? qd : '0;
    m_irq = |(m_raw & m_en);
    m_raw = (m_raw & ~qmask) | ev;
    m_en  = (m_en & ~cmask) | smask;
    #1;
    check_all(req);
  endtask

  task automatic idle(input string req);
    step('0, 1'b0, '0, 1'b0, '0, 1'b0, '0, req);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_all("R1 after release");

    step(2'b01, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R2 event while disabled");
    idle("R2 masked event kept");
    check("R2 raw held", 32'(raw_o), 32'h1);
    check("R9 irq low while masked", 32'(irq_o), 32'h0);

    step('0, 1'b1, 2'b01, 1'b0, '0, 1'b0, '0, "R3 enable set");
    idle("R9 irq one cycle later");
    check("R9 irq high", 32'(irq_o), 32'h1);
    repeat (3) idle("R9 level held");
    check("R9 irq still high", 32'(irq_o), 32'h1);

    step('0, 1'b0, 2'b11, 1'b0, 2'b11, 1'b0, 2'b11, "R10 strobes low");
    check("R10 en unchanged", 32'(en_o), 32'h1);
    check("R10 raw unchanged", 32'(raw_o), 32'h1);

    step(2'b01, 1'b0, '0, 1'b0, '0, 1'b1, 2'b01, "R7 event beats clear");
    check("R7 raw kept", 32'(raw_o), 32'h1);

    step('0, 1'b1, 2'b10, 1'b1, 2'b11, 1'b0, '0, "R5 set beats clear");
    check("R5 bit1 set", 32'(en_o), 32'h2);
    check("R4 bit0 cleared", 32'(en_o[0]), 32'h0);

    step('0, 1'b1, 2'b00, 1'b0, '0, 1'b0, '0, "R3 zero data no change");
    step('0, 1'b0, '0, 1'b1, 2'b00, 1'b0, '0, "R4 zero data no change");
    step(2'b10, 1'b0, '0, 1'b0, '0, 1'b0, '0, "R2 second source");
    idle("R9 second source irq");
    step('0, 1'b0, '0, 1'b0, '0, 1'b1, 2'b01, "R6 clear bit0 only");
    check("R6 bit1 kept", 32'(raw_o), 32'h2);
    step('0, 1'b0, '0, 1'b0, '0, 1'b1, 2'b10, "R6 clear bit1");
    idle("R9 irq drops");
    check("R9 irq low", 32'(irq_o), 32'h0);

    begin
      logic [10:0] lf = 11'h5a3;
      for (int i = 0; i < 8000; i++) begin
        lf = {lf[9:0], lf[10] ^ lf[8]};
        step(lf[1:0], lf[2], lf[4:3], lf[5], lf[7:6], lf[8], lf[10:9], "R10 sweep");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule